// File: doc/BRIEF.md
# Pulse-Width Symbol Receiver

This block turns the serial pulse train of a remote-control encoder back into trinary digits. It runs on a sampling clock that is a fixed multiple of the encoder clock. The line is brought in through a two-stage synchronizer. Every rising edge starts a delay counter, and when that counter expires the line is sampled once. If the line is still high, the pulse is long. If it has dropped, the pulse is short. Pulses are taken in pairs, and each pair is reported as one digit together with its position in the word.

A single low-time counter watches the quiet periods on the line. A low stretch of about two data periods closes the current word, which is the gap between the two copies of a word. A stretch of about four data periods closes the whole transmission. Checks that need more than one digit, such as address comparison or data latching, belong to a consumer placed after this block. That consumer uses the digit strobe, the end-of-word strobe and the end-of-transmission strobe.

Top module: `pwsym_rx`

## Requirements
- R1: After reset all strobes are low and `dig_code` and `dig_idx` are 0. A line held low after reset produces no strobe.
- R2: A high pulse of at least SAMPLE_DLY+1 sampling cycles, measured at `line_in`, is long. A high pulse of SAMPLE_DLY cycles or fewer is short.
- R3: Pulses pair into digits. Short-short gives code 2'b00, long-long gives 2'b01, and long-short (open) gives 2'b10. Each digit raises `dig_vld` for one cycle with `dig_idx` counting 1, 2, and so on from the first pulse after a gap.
- R4: A low stretch of EOW_GAP or more cycles after a pulse gives exactly one `eow` strobe and restarts the index at 1. A shorter low stretch inside a word does not end the word.
- R5: A low stretch of EOT_GAP or more cycles gives exactly one `eot` strobe, EOT_GAP-EOW_GAP cycles after the `eow` of the same stretch. A stretch of EOT_GAP-1 cycles gives none.
- R6: A short-then-long pair raises `err` for one cycle and reports no digit. No further `dig_vld` appears until the next `eow`, and that `eow` carries no count error.
- R7: When a word ends with a complete-digit count other than DIGITS, or with an unpaired pulse left over, `err` is raised in the same cycle as `eow`. Digits past position DIGITS are not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Serial pulse line from the encoder, asynchronous |
| dig_vld | output | 1 | One-cycle strobe for a decoded digit |
| dig_code | output | 2 | Digit code: 00 zero, 01 one, 10 open |
| dig_idx | output | $clog2(DIGITS+2) | Position of the digit in the word, from 1 |
| eow | output | 1 | One-cycle end-of-word strobe |
| eot | output | 1 | One-cycle end-of-transmission strobe |
| err | output | 1 | One-cycle strobe for an illegal pair or a bad digit count |

## Verification
The end-of-word decision and the digit-count check land in the same cycle. A malformed word therefore shows up as `eow` and `err` together. This case is provoked in three ways: a word cut short after five digits, a word with one unpaired pulse after nine digits, and a word with ten digits. A single line of idle after the first pulse of a word also ends up in this case. The scoreboard expects one combined item with both bits set, so a design that raises the two strobes in different cycles, or drops one of them, fails the comparison.

// File: rtl/pwsym_rx.sv
module pwsym_rx #(
  parameter int SAMPLE_DLY = 14,
  parameter int EOW_GAP    = 128,
  parameter int EOT_GAP    = 256,
  parameter int DIGITS     = 9,
  localparam int DW = $clog2(SAMPLE_DLY + 1),
  localparam int GW = $clog2(EOT_GAP + 1),
  localparam int IW = $clog2(DIGITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  output logic          dig_vld,
  output logic [1:0]    dig_code,
  output logic [IW-1:0] dig_idx,
  output logic          eow,
  output logic          eot,
  output logic          err
);

  logic          s1, s2, s3;
  logic [DW-1:0] dly;
  logic          armed;
  logic [GW-1:0] lowc;
  logic          half, first_long, bad, word_open, active;
  logic [IW-1:0] idx;

  wire rise    = s2 & ~s3;
  wire samp    = armed && (dly == '0);
  wire illegal = ~first_long & s2;
  wire [1:0] code = {first_long & ~s2, first_long & s2};
  wire hit_eow = ~s2 && (lowc == GW'(EOW_GAP - 1)) && word_open;
  wire hit_eot = ~s2 && (lowc == GW'(EOT_GAP - 1)) && active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {line_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     lowc <= '0;
    else if (s2)                    lowc <= '0;
    else if (lowc != GW'(EOT_GAP))  lowc <= lowc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0; armed <= 1'b0;
      half <= 1'b0; first_long <= 1'b0; bad <= 1'b0;
      word_open <= 1'b0; active <= 1'b0; idx <= '0;
      dig_vld <= 1'b0; dig_code <= '0; dig_idx <= '0;
      eow <= 1'b0; eot <= 1'b0; err <= 1'b0;
    end else begin
      dig_vld <= 1'b0;
      eow     <= 1'b0;
      eot     <= 1'b0;
      err     <= 1'b0;

      if (rise) begin
        armed     <= 1'b1;
        dly       <= DW'(SAMPLE_DLY - 1);
        word_open <= 1'b1;
        active    <= 1'b1;
      end else if (samp) begin
        armed <= 1'b0;
      end else if (armed) begin
        dly <= dly - 1'b1;
      end

      if (samp) begin
        if (!half) begin
          half       <= 1'b1;
          first_long <= s2;
        end else begin
          half <= 1'b0;
          if (!bad) begin
            if (illegal) begin
              err <= 1'b1;
              bad <= 1'b1;
            end else begin
              if (idx < IW'(DIGITS)) begin
                dig_vld  <= 1'b1;
                dig_code <= code;
                dig_idx  <= idx + 1'b1;
              end
              if (idx <= IW'(DIGITS)) idx <= idx + 1'b1;
            end
          end
        end
      end

      if (hit_eow) begin
        eow       <= 1'b1;
        err       <= !bad && (half || idx != IW'(DIGITS));
        half      <= 1'b0;
        bad       <= 1'b0;
        idx       <= '0;
        word_open <= 1'b0;
      end

      if (hit_eot) begin
        eot    <= 1'b1;
        active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwsym_rx_chk.sv
module pwsym_rx_chk #(
  parameter int EOW_GAP = 128,
  parameter int EOT_GAP = 256,
  parameter int DIGITS  = 9,
  parameter int IW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dig_vld,
  input logic [1:0]    dig_code,
  input logic [IW-1:0] dig_idx,
  input logic          eow,
  input logic          eot,
  input logic          err
);

  localparam int CW = $clog2(EOT_GAP + 1);
  logic [CW-1:0] since_eow;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          since_eow <= CW'(EOT_GAP);
    else if (eow)                        since_eow <= '0;
    else if (since_eow != CW'(EOT_GAP))  since_eow <= since_eow + 1'b1;

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dig_vld |-> (dig_idx >= IW'(1) && dig_idx <= IW'(DIGITS)));

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dig_vld |-> dig_code != 2'b11);

  p_digit_not_at_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dig_vld |-> !eow && !eot);

  p_eow_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eow |=> !eow);

  p_eot_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> since_eow == CW'(EOT_GAP - EOW_GAP - 1));

  p_eot_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);

  p_err_no_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !dig_vld);

endmodule

bind pwsym_rx pwsym_rx_chk #(
  .EOW_GAP(EOW_GAP), .EOT_GAP(EOT_GAP), .DIGITS(DIGITS), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dig_vld(dig_vld), .dig_code(dig_code),
  .dig_idx(dig_idx), .eow(eow), .eot(eot), .err(err)
);

// File: tb/pwsym_rx_bench.sv
module pwsym_rx_bench;
  localparam int SDLY = 14, EOWG = 128, EOTG = 256, NDIG = 9;

  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b0;
  logic dig_vld, eow, eot, err;
  logic [1:0] dig_code;
  logic [3:0] dig_idx;

  always #10 clk = ~clk;

  pwsym_rx #(.SAMPLE_DLY(SDLY), .EOW_GAP(EOWG), .EOT_GAP(EOTG), .DIGITS(NDIG)) u_pwsym_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .dig_vld(dig_vld),
    .dig_code(dig_code), .dig_idx(dig_idx), .eow(eow), .eot(eot), .err(err));

  typedef struct packed {
    logic       dv;
    logic [1:0] code;
    logic [3:0] idx;
    logic       ew;
    logic       et;
    logic       er;
  } item_t;

  item_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  int m_half = 0, m_first = 0, m_idx = 0, m_bad = 0, m_open = 0, m_active = 0, last_lo = 0;

  function automatic string tag_of(item_t it);
    if (it.er && it.ew) return "R7";
    if (it.er)          return "R6";
    if (it.et)          return "R5";
    if (it.ew)          return "R4";
    return "R3";
  endfunction

  task automatic expect_item(item_t it);
    exp_q.push_back(it);
  endtask

  // Driver: one high pulse then a low stretch; the model pushes what must follow.
  task automatic pulse(input int hi, input int lo, input bit lng);
    item_t it;
    m_open = 1; m_active = 1;
    if (m_half == 0) begin
      m_half = 1; m_first = lng;
    end else begin
      m_half = 0;
      if (m_bad == 0) begin
        if (m_first == 0 && lng) begin
          it = '0; it.er = 1'b1; expect_item(it);
          m_bad = 1;
        end else begin
          if (m_idx < NDIG) begin
            it = '0; it.dv = 1'b1;
            it.code = (m_first != 0 && !lng) ? 2'b10 : (lng ? 2'b01 : 2'b00);
            it.idx = 4'(m_idx + 1);
            expect_item(it);
          end
          if (m_idx <= NDIG) m_idx++;
        end
      end
    end
    line_in = 1'b1;
    repeat (hi) @(negedge clk);
    line_in = 1'b0;
    repeat (lo) @(negedge clk);
    last_lo = lo;
  endtask

  task automatic digit(input int c);
    case (c)
      0:       begin pulse(8, 24, 1'b0);  pulse(8, 24, 1'b0); end
      1:       begin pulse(24, 8, 1'b1);  pulse(24, 8, 1'b1); end
      default: begin pulse(24, 8, 1'b1);  pulse(8, 24, 1'b0); end
    endcase
  endtask

  task automatic word(input int n, input int seed);
    for (int i = 0; i < n; i++) digit((i * 2 + seed) % 3);
  endtask

  task automatic gap(input int total);
    item_t it;
    if (total >= EOWG && m_open != 0) begin
      it = '0; it.ew = 1'b1;
      it.er = (m_bad == 0) && (m_half != 0 || m_idx != NDIG);
      expect_item(it);
      m_half = 0; m_idx = 0; m_bad = 0; m_open = 0;
    end
    if (total >= EOTG && m_active != 0) begin
      it = '0; it.et = 1'b1; expect_item(it);
      m_active = 0;
    end
    repeat (total - last_lo) @(negedge clk);
    last_lo = total;
  endtask

  // Monitor: pop and compare on every strobe.
  always @(negedge clk) begin
    if (rst_n && !done && (dig_vld || eow || eot || err)) begin
      item_t got, want;
      got = '0;
      got.dv = dig_vld; got.ew = eow; got.et = eot; got.er = err;
      if (dig_vld) begin got.code = dig_code; got.idx = dig_idx; end
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected strobe: actual %h expected none", tag_of(got), got);
      end else begin
        want = exp_q.pop_front();
        if (got !== want) begin
          fails++;
          $display("FAIL %s item mismatch: actual %h expected %h", tag_of(want), got, want);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    checks++;
    if ({dig_vld, eow, eot, err, dig_code, dig_idx} !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual %b expected 0", {dig_vld, eow, eot, err, dig_code, dig_idx});
    end
    // R1: long idle after reset gives no strobe (monitor flags any)
    repeat (300) @(negedge clk);

    // R3, R4, R5: two copies of a word, then end of transmission
    word(NDIG, 0); gap(210);
    word(NDIG, 0); gap(300);

    // R2: pulses at the decision boundary (15 high = long, 14 high = short)
    for (int i = 0; i < NDIG; i++) begin
      if (i % 3 == 0)      begin pulse(15, 17, 1'b1); pulse(14, 18, 1'b0); end
      else if (i % 3 == 1) begin pulse(15, 17, 1'b1); pulse(15, 17, 1'b1); end
      else                 begin pulse(14, 18, 1'b0); pulse(14, 18, 1'b0); end
    end
    gap(300);

    // R4: an in-word low of EOW_GAP-1 does not end the word
    digit(1); pulse(8, EOWG - 1, 1'b0); pulse(8, 24, 1'b0);
    word(NDIG - 2, 1);
    // R5: EOT_GAP-1 low ends the word only; EOT_GAP ends the transmission
    gap(EOTG - 1);
    word(NDIG, 2); gap(EOTG);

    // R6: short-then-long pair, rest of the word ignored
    digit(0); digit(1); pulse(8, 24, 1'b0); pulse(24, 8, 1'b1);
    word(5, 1); gap(300);

    // R7: too few digits, leftover pulse, too many digits, idle mid-digit
    word(5, 2); gap(300);
    word(NDIG, 1); pulse(24, 8, 1'b1); gap(300);
    word(NDIG + 1, 0); gap(300);
    pulse(24, 8, 1'b1); gap(300);

    repeat (50) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 pending items: actual %0d expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule